// File: doc/BRIEF.md
# Serial Gigabit PHY Lane Interrupt Register Block

This block is the memory-mapped interrupt and link-configuration unit that sits beside one serial gigabit PHY lane. Event pulses from the lane's 8b/10b decoder set sticky bits in an event status register. A mask register selects which of those bits drive a single level interrupt output, which is registered. A small set of configuration registers for autonegotiation and speed/duplex is also kept here, together with a read-only view of the receive clock-recovery alignment flag.

Status is not write-one-to-clear. To clear it, software first writes the bits it wants cleared into a clear-select register, and then sets bit 0 of a command register (the global clear). The selected status bits drop a fixed number of cycles later. While both registers stay set, the selected bits stay at zero even if new events arrive on them. Software finishes by writing zero to the command register and then to the clear-select register, after which events latch again.

Access is through a plain register port with byte offsets, a write strobe and a read strobe. Read data returns one cycle after the read strobe.

Top module: `sgmii_irq_regs`

## Requirements
- R1: After reset every register reads as zero and `irq_out` is low.
- R2: A pulse on `evt_in[i]` sets status bit i, read at offset 0xB8. Bit 7 is the code-group error and bit 6 is the running-disparity error. The bit stays set until it is cleared.
- R3: Writes to status (0xB8), to the alignment view (0xD4) or to any offset outside {0x48, 0x74, 0xAC, 0xB0, 0xB4, 0xB8, 0xD4} change nothing. Reads of an undefined offset return zero.
- R4: Status bits never drop while command bit 0 (offset 0xAC) is zero, whatever the clear-select register (0xB0) holds.
- R5: Selected status bits clear on the 3rd rising edge after the edge that writes command bit 0 to one. A read issued at each of the first three of those edges still returns them set.
- R6: While command bit 0 and a clear-select bit stay set after the drop, new events on that bit leave it clear. Events on bits that are not selected still latch.
- R7: After command and clear-select are written back to zero, events latch again on the previously cleared bits.
- R8: `irq_out` equals the OR of (status AND mask, offset 0xB4), registered once. A mask of zero keeps it low, and a mask of 0xC0 passes only the two decode errors.
- R9: The autonegotiation config (0x48) keeps only bits 0 (enable), 4 (force RX config) and 5 (force TX config). The speed config (0x74) keeps only bits 0 (100 Mb/s), 1 (1000 Mb/s) and 4 (duplex). All other bits read as zero.
- R10: Bit 6 of offset 0xD4 shows `cdr_aligned_in` delayed by one register. All other bits of 0xD4 read as zero.
- R11: Command keeps only bit 0. Clear-select and mask keep bits 7:0.
- R12: `rdata` is updated on the edge where `rd_en` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| evt_in | input | 8 | Decoder event pulses, one per status bit |
| cdr_aligned_in | input | 1 | Clock-recovery alignment flag |
| irq_out | output | 1 | Registered level interrupt |

## Verification
The bench sweeps all 256 mask values against several latched status patterns. A design that used the wrong mask polarity, or let unmasked bits through, would raise the interrupt on the wrong codes. The bench reads status on each edge after the global clear. A design that cleared at once, or one cycle late, would return the wrong value in one of those cycles. It also fires events while the clear is held and again after it is released. This catches a design that re-latches a bit during the hold, drops unselected bits, or stays blind after the clear is finished. Writes to read-only and unmapped offsets, and all-ones writes to the configuration registers, expose any register that decodes sloppily or keeps bits it should not.

// File: rtl/sgmii_irq_pkg.sv
package sgmii_irq_pkg;
  localparam int OFS_W = 8;
  localparam logic [OFS_W-1:0] OFS_ANEG   = 8'h48;
  localparam logic [OFS_W-1:0] OFS_SPEED  = 8'h74;
  localparam logic [OFS_W-1:0] OFS_CMD    = 8'hAC;
  localparam logic [OFS_W-1:0] OFS_CLRSEL = 8'hB0;
  localparam logic [OFS_W-1:0] OFS_MASK   = 8'hB4;
  localparam logic [OFS_W-1:0] OFS_STAT   = 8'hB8;
  localparam logic [OFS_W-1:0] OFS_ALIGN  = 8'hD4;
  // field positions
  localparam int B_AN_EN    = 0;
  localparam int B_FRC_RX   = 4;
  localparam int B_FRC_TX   = 5;
  localparam int B_SPD_100  = 0;
  localparam int B_SPD_1000 = 1;
  localparam int B_DUPLEX   = 4;
  localparam int B_GCLR     = 0;
  localparam int B_ALIGN    = 6;

  typedef struct packed {
    logic an_en;
    logic frc_rx;
    logic frc_tx;
    logic spd100;
    logic spd1000;
    logic duplex;
  } link_cfg_t;

  function automatic logic ofs_defined(input logic [OFS_W-1:0] a);
    return (a == OFS_ANEG) || (a == OFS_SPEED) || (a == OFS_CMD) ||
           (a == OFS_CLRSEL) || (a == OFS_MASK) || (a == OFS_STAT) ||
           (a == OFS_ALIGN);
  endfunction
endpackage

// File: rtl/sgmii_cfg_regs.sv
module sgmii_cfg_regs
  import sgmii_irq_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  addr,
  input  logic [7:0]        wdata,
  output link_cfg_t         cfg_q,
  output logic              gclr_q,
  output logic [STAT_W-1:0] clrsel_q,
  output logic [STAT_W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      gclr_q   <= 1'b0;
      clrsel_q <= '0;
      mask_q   <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_ANEG: begin
          cfg_q.an_en  <= wdata[B_AN_EN];
          cfg_q.frc_rx <= wdata[B_FRC_RX];
          cfg_q.frc_tx <= wdata[B_FRC_TX];
        end
        OFS_SPEED: begin
          cfg_q.spd100  <= wdata[B_SPD_100];
          cfg_q.spd1000 <= wdata[B_SPD_1000];
          cfg_q.duplex  <= wdata[B_DUPLEX];
        end
        OFS_CMD:    gclr_q   <= wdata[B_GCLR];
        OFS_CLRSEL: clrsel_q <= wdata[STAT_W-1:0];
        OFS_MASK:   mask_q   <= wdata[STAT_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sgmii_irq_status.sv
module sgmii_irq_status #(
  parameter int STAT_W  = 8,
  parameter int CLR_DLY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] evt,
  input  logic [STAT_W-1:0] clrsel,
  input  logic              gclr,
  output logic [STAT_W-1:0] status_q
);
  localparam int CNT_W = $clog2(CLR_DLY + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(CLR_DLY);
  localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(CLR_DLY - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic              clr_active;
  logic [STAT_W-1:0] kill;

  assign clr_active = gclr && (cnt_q >= CNT_FIRE);

  generate
    for (genvar i = 0; i < STAT_W; i++) begin : g_kill
      assign kill[i] = clr_active & clrsel[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!gclr) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q | evt) & ~kill;
  end
endmodule

// File: rtl/sgmii_irq_regs.sv
module sgmii_irq_regs
  import sgmii_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int STAT_W  = 8,
  parameter int CLR_DLY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [OFS_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [STAT_W-1:0] evt_in,
  input  logic              cdr_aligned_in,
  output logic              irq_out
);
  link_cfg_t         cfg_q;
  logic              gclr_q;
  logic [STAT_W-1:0] clrsel_q;
  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] status_q;
  logic              align_q;
  logic [DATA_W-1:0] rd_mux;
  logic              wdata_unused_bits;

  assign wdata_unused_bits = ^wdata[DATA_W-1:8];

  sgmii_cfg_regs #(.STAT_W(STAT_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata[7:0]),
    .cfg_q(cfg_q), .gclr_q(gclr_q), .clrsel_q(clrsel_q), .mask_q(mask_q)
  );

  sgmii_irq_status #(.STAT_W(STAT_W), .CLR_DLY(CLR_DLY)) u_stat (
    .clk(clk), .rst(rst), .evt(evt_in), .clrsel(clrsel_q), .gclr(gclr_q),
    .status_q(status_q)
  );

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_ANEG: begin
        rd_mux[B_AN_EN]  = cfg_q.an_en;
        rd_mux[B_FRC_RX] = cfg_q.frc_rx;
        rd_mux[B_FRC_TX] = cfg_q.frc_tx;
      end
      OFS_SPEED: begin
        rd_mux[B_SPD_100]  = cfg_q.spd100;
        rd_mux[B_SPD_1000] = cfg_q.spd1000;
        rd_mux[B_DUPLEX]   = cfg_q.duplex;
      end
      OFS_CMD:    rd_mux[B_GCLR]       = gclr_q;
      OFS_CLRSEL: rd_mux[STAT_W-1:0]   = clrsel_q;
      OFS_MASK:   rd_mux[STAT_W-1:0]   = mask_q;
      OFS_STAT:   rd_mux[STAT_W-1:0]   = status_q;
      OFS_ALIGN:  rd_mux[B_ALIGN]      = align_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      align_q <= 1'b0;
      irq_out <= 1'b0;
      rdata   <= '0;
    end else begin
      align_q <= cdr_aligned_in;
      irq_out <= |(status_q & mask_q);
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/sgmii_irq_chk.sv
module sgmii_irq_chk
  import sgmii_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int STAT_W  = 8,
  parameter int CLR_DLY = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [OFS_W-1:0]  addr,
  input logic [DATA_W-1:0] rdata,
  input logic [STAT_W-1:0] status,
  input logic [STAT_W-1:0] mask,
  input logic [STAT_W-1:0] clrsel,
  input logic              gclr,
  input logic              irq
);
  localparam int HW = $clog2(CLR_DLY + 1);
  logic [HW-1:0] held;

  always_ff @(posedge clk) begin
    if (rst || !gclr)              held <= '0;
    else if (held != HW'(CLR_DLY)) held <= held + 1'b1;
  end

  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq); // R8
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(status & mask))); // R8
  AST_NO_DROP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !gclr |=> ((status & $past(status)) == $past(status))); // R4
  AST_HELD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (held == HW'(CLR_DLY) && $stable(clrsel)) |-> ((status & clrsel) == '0)); // R6
  AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !ofs_defined(addr)) |=> (rdata == '0)); // R3
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R12
endmodule

bind sgmii_irq_regs sgmii_irq_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W), .CLR_DLY(CLR_DLY)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .status(status_q), .mask(mask_q), .clrsel(clrsel_q), .gclr(gclr_q), .irq(irq_out)
);

// File: tb/sim_sgmii_irq_regs.sv
`timescale 1ns/1ps
module sim_sgmii_irq_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  evt_in = '0;
  logic        cdr_aligned_in = 1'b0;
  logic        irq_out;
  int          n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  sgmii_irq_regs u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .cdr_aligned_in(cdr_aligned_in),
    .irq_out(irq_out));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [7:0] e);
    evt_in = e;
    @(posedge clk); @(negedge clk);
    evt_in = '0;
  endtask

  task automatic clear_all(input logic [7:0] bits);
    wr(8'hB0, {24'h0, bits});
    wr(8'hAC, 32'h1);
    repeat (4) begin @(posedge clk); @(negedge clk); end
    wr(8'hAC, 32'h0);
    wr(8'hB0, 32'h0);
  endtask

  initial begin
    #400000;
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0] pats [4] = '{8'hC0, 8'h40, 8'h80, 8'h3D};
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    check("R1 irq", {31'h0, irq_out}, 32'h0);
    foreach (pats[k]) begin end
    rd(8'h48, v); check("R1 aneg", v, 0);
    rd(8'h74, v); check("R1 speed", v, 0);
    rd(8'hAC, v); check("R1 cmd", v, 0);
    rd(8'hB0, v); check("R1 clrsel", v, 0);
    rd(8'hB4, v); check("R1 mask", v, 0);
    rd(8'hB8, v); check("R1 status", v, 0);
    rd(8'hD4, v); check("R1 align", v, 0);

    // R9, R11: writable bit sets
    wr(8'h48, 32'hFFFF_FFFF); rd(8'h48, v); check("R9 aneg", v, 32'h31);
    wr(8'h74, 32'hFFFF_FFFF); rd(8'h74, v); check("R9 speed", v, 32'h13);
    wr(8'h74, 32'h0000_0002); rd(8'h74, v); check("R9 speed 1000", v, 32'h2);
    wr(8'hB4, 32'hFFFF_FF5A); rd(8'hB4, v); check("R11 mask", v, 32'h5A);
    wr(8'hB0, 32'hFFFF_FFA5); rd(8'hB0, v); check("R11 clrsel", v, 32'hA5);
    wr(8'hB0, 32'h0); wr(8'hB4, 32'h0);

    // R3: writes to read-only / undefined offsets; undefined reads zero
    wr(8'hB8, 32'hFF); rd(8'hB8, v); check("R3 status write ignored", v, 0);
    wr(8'hD4, 32'hFF); rd(8'hD4, v); check("R3 align write ignored", v, 0);
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h48 && a != 8'h74 && a != 8'hAC && a != 8'hB0 &&
          a != 8'hB4 && a != 8'hB8 && a != 8'hD4) begin
        wr(a[7:0], 32'hFFFF_FFFF);
        rd(a[7:0], v); check("R3 undefined read", v, 0);
      end
    end
    rd(8'h74, v); check("R3 speed untouched", v, 32'h2);
    rd(8'hB4, v); check("R3 mask untouched", v, 0);

    // R10
    cdr_aligned_in = 1'b1; @(posedge clk); @(negedge clk);
    rd(8'hD4, v); check("R10 aligned", v, 32'h40);
    cdr_aligned_in = 1'b0; @(posedge clk); @(negedge clk);
    rd(8'hD4, v); check("R10 not aligned", v, 0);

    // R2 + R8: mask sweep over several status patterns
    foreach (pats[k]) begin
      clear_all(8'hFF);
      pulse(pats[k]);
      rd(8'hB8, v); check("R2 latch", v, {24'h0, pats[k]});
      for (int m = 0; m < 256; m++) begin
        wr(8'hB4, m);
        @(posedge clk); @(negedge clk);
        check("R8 irq", {31'h0, irq_out}, {31'h0, |(pats[k] & m[7:0])});
      end
      wr(8'hB4, 32'h0);
    end

    // R4: clear-select without command does nothing
    clear_all(8'hFF);
    pulse(8'hC1);
    wr(8'hB0, 32'hFF);
    repeat (6) begin @(posedge clk); @(negedge clk); end
    rd(8'hB8, v); check("R4 no clear without cmd", v, 32'hC1);

    // R5: exact drop timing, clear-select 0xC0 (bit 0 must stay)
    wr(8'hB0, 32'hC0);
    wr(8'hAC, 32'h1);
    rd(8'hB8, v); check("R5 edge1", v, 32'hC1);
    rd(8'hB8, v); check("R5 edge2", v, 32'hC1);
    rd(8'hB8, v); check("R5 edge3", v, 32'hC1);
    rd(8'hB8, v); check("R5 edge4 dropped", v, 32'h01);

    // R6: hold keeps selected bits clear, others latch
    pulse(8'h82);
    rd(8'hB8, v); check("R6 held", v, 32'h03);
    wr(8'hB4, 32'hC0);
    @(posedge clk); @(negedge clk);
    check("R8 decode-only mask while held", {31'h0, irq_out}, 0);

    // R7: finish and re-arm
    wr(8'hAC, 32'h0);
    wr(8'hB0, 32'h0);
    pulse(8'h40);
    rd(8'hB8, v); check("R7 relatch", v, 32'h43);
    check("R8 irq decode bit", {31'h0, irq_out}, 1);

    // R12: rdata holds without rd_en
    addr = 8'h48; @(posedge clk); @(negedge clk);
    check("R12 hold", rdata, 32'h43);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule